// File: doc/BRIEF.md
# Serial Data-In Steering Unit

This block sits between three serial data-in lines from audio codecs and two receive DMA engines. It follows the frame timing on every input and watches each line's tag slot. When a codec answers a register read, it marks the frame, slot 1 and slot 2 as valid and returns the data in slot 2. The block then records which physical line carried that answer. Software can read this 2-bit line index at any time. No command is needed to arm the capture.

Software uses the recorded index to learn which codec sits on which line. It then programs one 2-bit line select for each DMA engine and sets a steer-enable bit. Until that bit is set, both engines receive the bitwise OR of all three inputs. After it is set, each engine receives only its selected line.

The block runs on the bit clock and samples the inputs on its rising edge. A frame is 256 bits long: a 16-bit tag followed by twelve 20-bit slots. Only one register read is outstanding on the link at a time.

Top module: `sdin_steer_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the unit clears the recorded index, the line selects and steer-enable. Both engine outputs read 0 after that edge.
- R2: With steer-enable clear, each engine output equals the OR of the three `sdin` bits sampled at the previous edge, whatever the line selects hold.
- R3: With steer-enable set, engine 0 outputs the line chosen by config bits [5:4] and engine 1 outputs the line chosen by bits [7:6]. Select value 0, 1 or 2 picks `sdin[0]`, `sdin[1]` or `sdin[2]`. The output appears one edge after sampling.
- R4: With steer-enable set, a select value of 3 drives a constant 0 to that engine.
- R5: A line shows a read return when frame bits 0, 1 and 2 (tag bits 15, 14, 13) are all 1 on it. Frame bit 0 is the bit sampled at the edge where `frame_sync` is first seen high. The line number (00, 01, 10) is written to `det_line` at the edge that samples frame bit 55, the last bit of slot 2. It is visible after that edge and not before.
- R6: If any of the three tag bits is 0 on a line, that line causes no update.
- R7: If several lines show a read return in the same frame, the lowest-numbered line is recorded.
- R8: Every read return overwrites the recorded index. No arming write is needed.
- R9: A frame is tracked only from a rising edge of `frame_sync`, for 256 bits. Input seen with no rising sync edge never changes the recorded index.
- R10: A write with `cfg_wr` high stores `cfg_wdata` bit 3 as steer-enable, bits [5:4] as the engine-0 select and bits [7:6] as the engine-1 select. `cfg_rdata` returns these fields in the same positions, the recorded index in bits [1:0], and 0 in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_sync | input | 1 | Frame marker; its rising edge begins a frame |
| sdin | input | 3 | Serial data-in lines 0 to 2 |
| cfg_wr | input | 1 | Write strobe for the steering fields |
| cfg_wdata | input | 5 | Write data, bits [7:3] of the configuration word |
| cfg_rdata | output | 8 | Configuration word with the recorded index in bits [1:0] |
| dma_rx | output | 2 | Steered serial stream, bit n for DMA engine n |
| det_line | output | 2 | Line index of the most recent read return |

## Verification
The assertions assume that `frame_sync` stays low long enough between frames for each rising edge to mark a real frame start. They also assume that `sdin` and the config inputs hold a defined value at every edge from reset onward. The bench keeps to both assumptions. It drives every input on the falling edge from time zero, holds sync high for the 16 tag bits and low for the rest of each 256-bit frame, and changes configuration only with single-cycle write strobes. Its no-sync test keeps `frame_sync` low for longer than a frame, so no rising edge appears.

// File: rtl/sdin_steer_pkg.sv
// Shared sizing for the serial data-in steering unit.
// Assumes three input lines, two engines and a 256-bit frame layout.
package sdin_steer_pkg;
    localparam int LINES      = 3;
    localparam int ENGINES    = 2;
    localparam int SEL_W      = $clog2(LINES + 1);
    localparam int IDX_W      = $clog2(LINES);
    localparam int FRAME_BITS = 256;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int TAG_BITS   = 16;
    localparam int SLOT_BITS  = 20;
    localparam int TAG_CHK    = 3;
    localparam int RET_LAST   = TAG_BITS + 2 * SLOT_BITS - 1;
endpackage

// File: rtl/sdin_frame_timer.sv
// Frame position tracker.
// Finds the rising edge of the sync input and counts bit positions 0..FRAME_BITS-1.
// Tracking stops after the last bit until the next rising edge of sync.
// Assumes sync is sampled on the same edge as the data lines.
module sdin_frame_timer
    import sdin_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync,
    output logic             pos_valid,
    output logic [POS_W-1:0] pos
);
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

    logic             sync_prev;
    logic             framed_q;
    logic [POS_W-1:0] pos_q;
    logic             start;

    // Decode the current bit position from the sync edge and the last position.
    always_comb begin
        start     = sync & ~sync_prev;
        pos_valid = start | (framed_q & (pos_q != LAST_POS));
        pos       = start ? '0 : pos_q + 1'b1;
    end

    // Hold the previous sync level and the frame position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_prev <= 1'b0;
            framed_q  <= 1'b0;
            pos_q     <= '0;
        end else begin
            sync_prev <= sync;
            framed_q  <= pos_valid;
            if (pos_valid) pos_q <= pos;
        end
    end

    assert_start_pos_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sync && !sync_prev) |=> (framed_q && pos_q == '0));
    assert_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (framed_q && pos_q == LAST_POS && !(sync && !sync_prev)) |=> !framed_q);
endmodule

// File: rtl/sdin_tag_watch.sv
// Tag watcher for one serial input line.
// Stores the frame, slot 1 and slot 2 valid bits from frame bits 0..2.
// Raises hit at the last bit of slot 2 when all three bits were set.
// Assumes pos/pos_valid come from the shared frame timer.
module sdin_tag_watch
    import sdin_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_bit,
    input  logic             pos_valid,
    input  logic [POS_W-1:0] pos,
    output logic             hit
);
    logic [TAG_CHK-1:0] tag_q;

    // Capture the leading tag bits, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q <= '0;
        end else if (pos_valid) begin
            for (int k = 0; k < TAG_CHK; k++) begin
                if (pos == POS_W'(k)) tag_q[TAG_CHK-1-k] <= line_bit;
            end
        end
    end

    // Flag a read return at the final slot-2 bit.
    always_comb begin
        hit = pos_valid && (pos == POS_W'(RET_LAST)) && (&tag_q);
    end
endmodule

// File: rtl/sdin_line_select.sv
// Output stage for one DMA engine.
// Sends the OR of all lines while steering is off, the selected line while
// it is on, and 0 for a select beyond the last line. Registered output.
module sdin_line_select
    import sdin_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic             steer_en,
    input  logic [SEL_W-1:0] sel,
    output logic             out_bit
);
    logic picked;

    // Choose the source bit for this engine.
    always_comb begin
        picked = 1'b0;
        if (!steer_en) begin
            picked = |lines;
        end else begin
            for (int i = 0; i < LINES; i++) begin
                if (sel == SEL_W'(i)) picked = lines[i];
            end
        end
    end

    // Register the engine's stream bit.
    always_ff @(posedge clk) begin
        if (!rst_n) out_bit <= 1'b0;
        else        out_bit <= picked;
    end

    assert_or_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !steer_en |=> (out_bit == $past(|lines)));
    assert_null_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_en && sel == {SEL_W{1'b1}}) |=> !out_bit);
endmodule

// File: rtl/sdin_steer_unit.sv
// Serial data-in steering unit (top).
// Watches each input's tag for a register read return, records the returning
// line, and steers the inputs to the DMA engines as configured.
// Assumes one outstanding register read and a single bit-clock domain.
module sdin_steer_unit
    import sdin_steer_pkg::*;
(
    input  logic               bit_clk,
    input  logic               rst_n,
    input  logic               frame_sync,
    input  logic [LINES-1:0]   sdin,
    input  logic               cfg_wr,
    input  logic [7:3]         cfg_wdata,
    output logic [7:0]         cfg_rdata,
    output logic [ENGINES-1:0] dma_rx,
    output logic [IDX_W-1:0]   det_line
);
    logic             pos_valid;
    logic [POS_W-1:0] pos;
    logic [LINES-1:0] hit;
    logic [IDX_W-1:0] low_idx;
    logic             steer_en;
    logic [SEL_W-1:0] sel_q [ENGINES];

    sdin_frame_timer u_timer (
        .clk       (bit_clk),
        .rst_n     (rst_n),
        .sync      (frame_sync),
        .pos_valid (pos_valid),
        .pos       (pos)
    );

    for (genvar g = 0; g < LINES; g++) begin : g_watch
        sdin_tag_watch u_watch (
            .clk       (bit_clk),
            .rst_n     (rst_n),
            .line_bit  (sdin[g]),
            .pos_valid (pos_valid),
            .pos       (pos),
            .hit       (hit[g])
        );
    end

    for (genvar e = 0; e < ENGINES; e++) begin : g_engine
        sdin_line_select u_sel (
            .clk      (bit_clk),
            .rst_n    (rst_n),
            .lines    (sdin),
            .steer_en (steer_en),
            .sel      (sel_q[e]),
            .out_bit  (dma_rx[e])
        );
    end

    // Pick the lowest-numbered line that returned read data.
    always_comb begin
        low_idx = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (hit[i]) low_idx = IDX_W'(i);
        end
    end

    // Record the returning line whenever any hit appears.
    always_ff @(posedge bit_clk) begin
        if (!rst_n)    det_line <= '0;
        else if (|hit) det_line <= low_idx;
    end

    // Hold the steering configuration written by software.
    always_ff @(posedge bit_clk) begin
        if (!rst_n) begin
            steer_en <= 1'b0;
            for (int e = 0; e < ENGINES; e++) sel_q[e] <= '0;
        end else if (cfg_wr) begin
            steer_en <= cfg_wdata[3];
            sel_q[0] <= cfg_wdata[5:4];
            sel_q[1] <= cfg_wdata[7:6];
        end
    end

    // Assemble the readable configuration word.
    always_comb begin
        cfg_rdata = {sel_q[1], sel_q[0], steer_en, 1'b0, det_line};
    end

    assert_idx_only_on_return_R5: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$stable(det_line) |-> $past(|hit));
    assert_lowest_wins_R7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        hit[0] |=> (det_line == '0));
    assert_cfg_store_R10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cfg_wr |=> (cfg_rdata[7:3] == $past(cfg_wdata)));
endmodule

// File: tb/sdin_steer_unit_tb.sv
module sdin_steer_unit_tb;
    logic       bit_clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_sync = 1'b0;
    logic [2:0] sdin = 3'b000;
    logic       cfg_wr = 1'b0;
    logic [7:3] cfg_wdata = 5'b0;
    logic [7:0] cfg_rdata;
    logic [1:0] dma_rx;
    logic [1:0] det_line;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    int exp_idx = 0;

    sdin_steer_unit u_dut (
        .bit_clk    (bit_clk),
        .rst_n      (rst_n),
        .frame_sync (frame_sync),
        .sdin       (sdin),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .dma_rx     (dma_rx),
        .det_line   (det_line)
    );

    always #5 bit_clk = ~bit_clk;

    // vector: {cfg[7:0], sdin[2:0], exp_engine0, exp_engine1}
    localparam int NV = 10;
    localparam logic [12:0] VEC [NV] = '{
        {8'h00, 3'b000, 1'b0, 1'b0},   // R2
        {8'h00, 3'b100, 1'b1, 1'b1},   // R2
        {8'h00, 3'b010, 1'b1, 1'b1},   // R2
        {8'hE0, 3'b001, 1'b1, 1'b1},   // R2 selects ignored while off
        {8'h18, 3'b010, 1'b1, 1'b0},   // R3 e0=line1 e1=line0
        {8'h18, 3'b001, 1'b0, 1'b1},   // R3
        {8'h68, 3'b100, 1'b1, 1'b0},   // R3 e0=line2 e1=line1
        {8'h68, 3'b011, 1'b0, 1'b1},   // R3
        {8'hF8, 3'b111, 1'b0, 1'b0},   // R4 both null
        {8'hB8, 3'b111, 1'b0, 1'b1}    // R4 e0 null, e1=line2
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        cfg_wr = 1'b1;
        cfg_wdata = v[7:3];
        @(posedge bit_clk);
        @(negedge bit_clk);
        cfg_wr = 1'b0;
    endtask

    // One 256-bit frame; ta/tb/tc are the three leading tag bits on lines 0..2.
    task automatic send_frame(input logic [2:0] t0, input logic [2:0] t1,
                              input logic [2:0] t2, input int new_idx);
        for (int p = 0; p < 256; p++) begin
            if (p == 55) chk("R5 before commit", int'(det_line), exp_idx);
            if (p == 56) chk("R5 after commit", int'(det_line), new_idx);
            frame_sync = (p < 16);
            if (p < 3) sdin = {t2[2-p], t1[2-p], t0[2-p]};
            else       sdin = {p[0], p[1] ^ p[3], p[2]};
            @(posedge bit_clk);
            @(negedge bit_clk);
        end
        exp_idx = new_idx;
        frame_sync = 1'b0;
    endtask

    initial begin
        @(negedge bit_clk);
        @(negedge bit_clk);
        // R1: reset state
        chk("R1 dma_rx", int'(dma_rx), 0);
        chk("R1 cfg_rdata", int'(cfg_rdata), 0);
        chk("R1 det_line", int'(det_line), 0);
        rst_n = 1'b1;
        @(negedge bit_clk);

        // Vector table: R2 R3 R4 R10
        for (int v = 0; v < NV; v++) begin
            cfg_write(VEC[v][12:5]);
            chk("R10 readback", int'(cfg_rdata), int'(VEC[v][12:5] & 8'hF8));
            sdin = VEC[v][4:2];
            @(posedge bit_clk);
            @(negedge bit_clk);
            chk("R2/R3/R4 engine0", int'(dma_rx[0]), int'(VEC[v][1]));
            chk("R2/R3/R4 engine1", int'(dma_rx[1]), int'(VEC[v][0]));
        end

        // Frame tests
        send_frame(3'b000, 3'b111, 3'b110, 1);   // R5 R8
        send_frame(3'b011, 3'b000, 3'b111, 2);   // R6 line0 missing frame bit
        send_frame(3'b000, 3'b111, 3'b111, 1);   // R7 lowest wins
        send_frame(3'b101, 3'b000, 3'b110, 1);   // R6 no update
        send_frame(3'b111, 3'b111, 3'b000, 0);   // R7 R8
        send_frame(3'b000, 3'b000, 3'b111, 2);   // R8
        chk("R10 index in readback", int'(cfg_rdata[1:0]), 2);

        // R9: no sync edge, all-ones input for more than a frame
        frame_sync = 1'b0;
        sdin = 3'b111;
        for (int c = 0; c < 300; c++) begin
            @(posedge bit_clk);
            @(negedge bit_clk);
        end
        chk("R9 no capture without sync", int'(det_line), 2);

        // R1: reset mid-operation clears state
        rst_n = 1'b0;
        @(posedge bit_clk);
        @(negedge bit_clk);
        chk("R1 reset clears index", int'(det_line), 0);
        chk("R1 reset clears config", int'(cfg_rdata), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog
    always @(posedge bit_clk) begin
        cycles++;
        if (cycles > 100000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule